// File: doc/BRIEF.md
# Fast PWM Timer with Shadowed Compares

This block is a 16-bit up-counter that produces single-slope pulse-width-modulated waveforms on two compare channels, A and B. The counter climbs by one on every enable tick from an internal clock divider and returns to zero on the tick where it equals the active TOP value. That one tick also raises the overflow flag and sets or clears each channel's waveform, depending on the channel's output mode. A compare match on the channel drives the opposite edge.

TOP comes from one of three places. It can be a fixed all-ones value 8, 9 or 10 bits wide. It can be an unshadowed capture register that acts on the next cycle. It can be the active channel-A compare value, which only changes at TOP. Software reaches the block through a single-cycle register write port. This port has no back-pressure: every cycle with `wr_en` high commits one write, so no ready signal exists. Flags are plain outputs and are cleared by writing ones to the flag address.

Top module: `pwmt_timer`

## Requirements
- R1: After reset, the count, all flags, both PWM outputs, all registers and the compare shadows read zero. The clock select is zero, so the counter holds.
- R2: On each enable tick the count rises by one, except on the tick where count equals TOP, when it goes to 0. The period is therefore TOP+1 ticks.
- R3: The overflow flag (flag bit 0) sets on the TOP tick. Writing a 1 to bit 0 at address 4 clears it. If the flag is set and cleared in the same cycle, the set wins.
- R4: Control register (address 0) layout: bits [1:0] select the TOP source, where 0 and 3 mean fixed, 1 means capture and 2 means compare A. Bits [3:2] select the fixed width, where 0 gives 0x00FF, 1 gives 0x01FF and 2 or 3 give 0x03FF. While a fixed TOP is selected, compare writes to address 1 (A) and address 2 (B) are masked to the fixed width.
- R5: A compare write goes to a shadow register. The shadow is copied into the active compare only on the TOP tick. Until then, the old value sets the match point and, in compare-A mode, the TOP.
- R6: Output mode 2, set by control bits [5:4] for A and [7:6] for B, is non-inverted. In this mode the output goes high on the TOP tick and low on the tick where count equals the active compare. It is therefore high while the count is between 0 and the compare value inclusive.
- R7: Output mode 3 is the inverse of mode 2. Output modes 0 and 1 hold the output low.
- R8: A compare value of 0 in mode 2 gives a high pulse one tick long on every wrap. A compare value equal to TOP gives a constant level. A compare value above TOP never matches, sets no match flag and keeps a constant level.
- R9: With the capture source selected, TOP is the capture register (address 3) from the next cycle on, and flag bit 3 sets on the TOP tick. If the new TOP is written below the count, the counter runs on to 0xFFFF and wraps to 0 with no overflow flag.
- R10: With the compare-A source selected, the channel-A match flag (bit 1) sets on the same tick as the overflow flag.
- R11: Control bits [10:8] select the tick rate: 0 stops the counter, and 1 to 5 divide the clock by 1, 8, 64, 256 and 1024.
- R12: A channel's match flag (bit 1 for A, bit 2 for B) sets on the tick where the count equals its active compare value, provided that value is not above TOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 3 | Register address: 0 control, 1 compare A, 2 compare B, 3 capture TOP, 4 flag clear |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| flag_ovf | output | 1 | Overflow flag (bit 0) |
| flag_cmp_a | output | 1 | Channel A match flag (bit 1) |
| flag_cmp_b | output | 1 | Channel B match flag (bit 2) |
| flag_top_cap | output | 1 | Capture-TOP flag (bit 3) |

## Verification
Some behaviours are checked on every cycle: the counter steps by one or wraps exactly at TOP, and it freezes between ticks. The overflow, capture and compare-A flags must follow a TOP tick, the active channel-A compare may change only at TOP, and the mode-2 output must rise at the wrap. Other behaviours can only be shown by the bench's sweeps over whole periods. These are the masking of compare writes, the duty-cycle edges for each compare value and mode, and the one-tick pulse and constant-level corners. The same holds for the long run to 0xFFFF after a capture TOP is written below the count, and for the divider ratios.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  typedef enum logic [1:0] {
    SRC_FIXED  = 2'd0,
    SRC_CAPT   = 2'd1,
    SRC_CMPA   = 2'd2,
    SRC_FIXED2 = 2'd3
  } top_src_e;

  // Control word, MSB first: clock select, mode B, mode A, fixed width, TOP source
  typedef struct packed {
    logic [2:0] clk_sel;
    logic [1:0] mode_b;
    logic [1:0] mode_a;
    logic [1:0] fix_w;
    top_src_e   src;
  } ctrl_t;

  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_CMPA = 1;
  localparam int unsigned ADR_CAPT = 3;
  localparam int unsigned ADR_FLAG = 4;

  localparam int unsigned FLG_OVF = 0;
endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  localparam int unsigned NDIV = 4;
  localparam int unsigned SH [NDIV] = '{3, 6, 8, 10};
  localparam int unsigned PW = SH[NDIV-1];

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    tick = 1'b0;
    if (sel == SW'(1)) tick = 1'b1;
    for (int i = 0; i < NDIV; i++) begin
      if (sel == SW'(i + 2)) begin
        tick = ((pre_q & PW'((1 << SH[i]) - 1)) == PW'((1 << SH[i]) - 1));
      end
    end
  end
endmodule

// File: rtl/pwmt_chan.sv
module pwmt_chan #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_shadow,
  input  logic [CW-1:0] wr_val,
  input  logic          tick,
  input  logic          top_tick,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] act,
  output logic          match,
  output logic          wav
);
  logic [CW-1:0] shadow_q, act_q;
  logic          wav_q;

  assign match = tick && (count == act_q) && (act_q <= top);
  assign act   = act_q;
  assign wav   = wav_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
      wav_q    <= 1'b0;
    end else begin
      if (wr_shadow) shadow_q <= wr_val;
      if (top_tick)  act_q    <= shadow_q;
      if (top_tick)   wav_q <= 1'b1;
      else if (match) wav_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwmt_timer.sv
module pwmt_timer
  import pwmt_pkg::*;
#(
  parameter int unsigned CW         = 16,
  parameter int unsigned AW         = 3,
  parameter int unsigned FIX_BASE_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] count,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          flag_ovf,
  output logic          flag_cmp_a,
  output logic          flag_cmp_b,
  output logic          flag_top_cap
);
  localparam int unsigned NCH    = 2;
  localparam int unsigned NFLAG  = NCH + 2;
  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam logic [CW-1:0] FIX_M0 = CW'((1 << FIX_BASE_W) - 1);
  localparam logic [CW-1:0] FIX_M1 = CW'((1 << (FIX_BASE_W + 1)) - 1);
  localparam logic [CW-1:0] FIX_M2 = CW'((1 << (FIX_BASE_W + 2)) - 1);

  ctrl_t                    ctrl_q;
  logic [CW-1:0]            capt_q, cnt_q, top_v, fix_mask, cmp_wdata;
  logic                     fixed_top, tick, at_top, top_tick;
  logic [NCH-1:0][CW-1:0]   act_v;
  logic [NCH-1:0]           match_v, wav_v, wr_shadow, pwm_v;
  logic [NCH-1:0][1:0]      mode_v;
  logic [NFLAG-1:0]         flag_q, flag_set, flag_clr;

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      capt_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADR_CTRL)) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_addr == AW'(ADR_CAPT)) capt_q <= wr_data;
    end
  end

  // TOP selection
  always_comb begin
    case (ctrl_q.fix_w)
      2'd0:    fix_mask = FIX_M0;
      2'd1:    fix_mask = FIX_M1;
      default: fix_mask = FIX_M2;
    endcase
    fixed_top = (ctrl_q.src == SRC_FIXED) || (ctrl_q.src == SRC_FIXED2);
    case (ctrl_q.src)
      SRC_CAPT: top_v = capt_q;
      SRC_CMPA: top_v = act_v[0];
      default:  top_v = fix_mask;
    endcase
  end

  assign cmp_wdata = fixed_top ? (wr_data & fix_mask) : wr_data;

  pwmt_prescale #(.SW(3)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (ctrl_q.clk_sel),
    .tick (tick)
  );

  // counter
  assign at_top   = (cnt_q == top_v);
  assign top_tick = tick && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= at_top ? '0 : cnt_q + 1'b1;
  end

  assign mode_v[0] = ctrl_q.mode_a;
  assign mode_v[1] = ctrl_q.mode_b;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign wr_shadow[g] = wr_en && (wr_addr == AW'(ADR_CMPA + g));

    pwmt_chan #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_shadow(wr_shadow[g]),
      .wr_val   (cmp_wdata),
      .tick     (tick),
      .top_tick (top_tick),
      .count    (cnt_q),
      .top      (top_v),
      .act      (act_v[g]),
      .match    (match_v[g]),
      .wav      (wav_v[g])
    );

    assign pwm_v[g] = mode_v[g][1] & (wav_v[g] ^ mode_v[g][0]);
  end

  // flags: hardware set wins over a write-one clear
  always_comb begin
    flag_set          = '0;
    flag_set[FLG_OVF] = top_tick;
    for (int i = 0; i < NCH; i++) flag_set[i + 1] = match_v[i];
    flag_set[NFLAG-1] = top_tick && (ctrl_q.src == SRC_CAPT);
    flag_clr = (wr_en && (wr_addr == AW'(ADR_FLAG))) ? wr_data[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  assign count        = cnt_q;
  assign pwm_a        = pwm_v[0];
  assign pwm_b        = pwm_v[1];
  assign flag_ovf     = flag_q[FLG_OVF];
  assign flag_cmp_a   = flag_q[1];
  assign flag_cmp_b   = flag_q[2];
  assign flag_top_cap = flag_q[NFLAG-1];
endmodule

// File: rtl/pwmt_timer_chk.sv
module pwmt_timer_chk
  import pwmt_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] top,
  input logic [1:0]    src,
  input logic [1:0]    mode_a,
  input logic [CW-1:0] act_a,
  input logic          pwm_a,
  input logic          flag_ovf,
  input logic          flag_cmp_a,
  input logic          flag_top_cap
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0) && !flag_ovf && !pwm_a);

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == top) |=> (cnt == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != top) |=> (cnt == $past(cnt) + CW'(1)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == top) |=> flag_ovf);

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cnt == top) |=> $stable(act_a));

  assert_pwm_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == top && mode_a == 2'd2 && !wr_en) |=> pwm_a);

  assert_capt_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == top && src == 2'(SRC_CAPT)) |=> flag_top_cap);

  assert_cmpa_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == top && src == 2'(SRC_CMPA)) |=> flag_cmp_a);
endmodule

bind pwmt_timer pwmt_timer_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .tick        (tick),
  .cnt         (cnt_q),
  .top         (top_v),
  .src         (ctrl_q.src),
  .mode_a      (ctrl_q.mode_a),
  .act_a       (act_v[0]),
  .pwm_a       (pwm_a),
  .flag_ovf    (flag_ovf),
  .flag_cmp_a  (flag_cmp_a),
  .flag_top_cap(flag_top_cap)
);

// File: tb/sim_pwmt_timer.sv
module sim_pwmt_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        pwm_a, pwm_b, flag_ovf, flag_cmp_a, flag_cmp_b, flag_top_cap;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmt_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b), .flag_ovf(flag_ovf),
    .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b), .flag_top_cap(flag_top_cap)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
  endtask

  // called at a falling edge; write commits on the next rising edge
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int cw(input int src, input int w, input int ma, input int mb, input int sel);
    return int'({sel[2:0], mb[1:0], ma[1:0], w[1:0], src[1:0]});
  endfunction

  function automatic int expo(input int m, input int c, input int cmp);
    int h;
    if (m < 2) return 0;
    h = (c <= cmp) ? 1 : 0;
    return (m == 3) ? 1 - h : h;
  endfunction

  task automatic wait_cnt(input string req, input int v, input int lim);
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      if (count == 16'(v)) return;
    end
    chk(req, count, v);
  endtask

  // waits for a wrap, then checks one full period of count and both outputs
  task automatic run_period(input string req, input int top, input int ca, input int cb,
                            input int ma, input int mb);
    wait_cnt(req, 0, 70000);
    for (int i = 0; i <= top; i++) begin
      chk({req, " count"}, count, i);
      chk({req, " pwm_a"}, pwm_a, expo(ma, i, ca));
      chk({req, " pwm_b"}, pwm_b, expo(mb, i, cb));
      @(negedge clk);
    end
    chk({req, " wrap"}, count, 0);
    chk("R3 ovf at wrap", flag_ovf, 1);
  endtask

  task automatic meas(input int sel, input int expn);
    int prev, n;
    wr(0, cw(2, 0, 2, 3, sel));
    prev = count;
    for (int k = 0; k < 3000 && count == 16'(prev); k++) @(negedge clk);
    prev = count;
    n = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      n++;
      if (count != 16'(prev)) break;
    end
    chk("R11 tick interval", n, expn);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit saw_max;
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 stopped
    chk("R1 count", count, 0);
    chk("R1 pwm_a", pwm_a, 0);
    chk("R1 pwm_b", pwm_b, 0);
    chk("R1 flags", {flag_top_cap, flag_cmp_b, flag_cmp_a, flag_ovf}, 0);
    repeat (5) @(negedge clk);
    chk("R11 stopped", count, 0);

    // fixed 8-bit TOP, A non-inverted, B inverted (R2, R6, R7)
    wr(1, 100); wr(2, 200);
    wr(0, cw(0, 0, 2, 3, 1));
    run_period("R2/R6", 255, 100, 200, 2, 3);

    // R3 clear and R12 match flags
    wr(4, 'hF);
    chk("R3 cleared", {flag_top_cap, flag_cmp_b, flag_cmp_a, flag_ovf}, 0);
    wait_cnt("R12", 100, 300);
    chk("R12 before match A", flag_cmp_a, 0);
    @(negedge clk);
    chk("R12 after match A", flag_cmp_a, 1);
    wait_cnt("R12", 201, 300);
    chk("R12 after match B", flag_cmp_b, 1);
    wait_cnt("R3", 255, 300);
    wr(4, 1);
    chk("R3 set wins over clear", flag_ovf, 1);

    // R5 shadowing; next period R8 one-tick pulse and constant level
    wr(1, 0); wr(2, 255);
    wait_cnt("R5", 50, 300);
    chk("R5 old compare A in use", pwm_a, 1);
    wait_cnt("R5", 220, 300);
    chk("R5 old compare B in use", pwm_b, 1);
    run_period("R8", 255, 0, 255, 2, 3);

    // R4 masking in 8-bit mode
    wr(1, 'h1234); wr(2, 'hFF80);
    wr(0, cw(0, 0, 2, 2, 1));
    run_period("R4/R6", 255, 'h34, 'h80, 2, 2);

    // R4 9-bit, R7 inverted and disconnected
    wr(0, cw(0, 1, 3, 1, 1));
    wr(1, 'h7F05); wr(2, 0);
    run_period("R4/R7", 511, 'h105, 0, 3, 1);

    // R4 10-bit, compare equals TOP (R8), mode 0 (R7)
    wr(0, cw(0, 2, 2, 0, 1));
    wr(1, 'h13FF); wr(2, 'h8123);
    run_period("R4/R8", 1023, 'h3FF, 'h123, 2, 0);

    // R9 capture TOP; R8 compare above TOP
    wr(3, 50); wr(1, 60); wr(2, 50);
    wr(0, cw(1, 0, 2, 3, 1));
    wait_cnt("R9", 0, 200);
    wr(4, 'hF);
    run_period("R9/R8", 50, 60, 50, 2, 3);
    chk("R9 capture flag", flag_top_cap, 1);
    chk("R8 no match above TOP", flag_cmp_a, 0);
    chk("R12 match at TOP on B", flag_cmp_b, 1);

    // R9 TOP written below count: run to 0xFFFF and wrap
    wait_cnt("R9", 30, 200);
    wr(4, 'hF);
    wr(3, 20);
    saw_max = 0;
    for (int k = 0; k < 70000; k++) begin
      @(negedge clk);
      if (count == 16'hFFFF) saw_max = 1;
      if (count == 16'h0000) break;
    end
    chk("R9 passed 0xFFFF", saw_max, 1);
    chk("R9 no ovf on wrap", flag_ovf, 0);
    chk("R9 no capture flag on wrap", flag_top_cap, 0);
    run_period("R9 new TOP", 20, 60, 50, 2, 3);

    // R10 compare A as TOP
    wr(1, 30);
    wait_cnt("R10", 0, 200);
    wr(0, cw(2, 0, 2, 3, 1));
    wr(4, 'hF);
    wait_cnt("R10", 30, 200);
    chk("R10 match A before TOP", flag_cmp_a, 0);
    chk("R10 ovf before TOP", flag_ovf, 0);
    @(negedge clk);
    chk("R10 wrap at 30", count, 0);
    chk("R10 match A with ovf", flag_cmp_a, 1);
    chk("R10 ovf", flag_ovf, 1);
    chk("R10 capture flag idle", flag_top_cap, 0);
    wr(1, 40);
    wait_cnt("R5", 30, 200);
    @(negedge clk);
    chk("R5 TOP change waits for wrap", count, 0);
    run_period("R10/R5", 40, 40, 50, 2, 3);

    // R11 divider ratios and stop
    meas(1, 1);
    meas(2, 8);
    meas(3, 64);
    meas(4, 256);
    meas(5, 1024);
    wr(0, cw(2, 0, 2, 3, 0));
    v = count;
    repeat (20) @(negedge clk);
    chk("R11 select 0 stops", count, v);

    done = 1;
    summary();
    $finish;
  end
endmodule